// File: doc/BRIEF.md
# Four-Decade BCD Up/Down Counter

This block holds a decimal count as four binary-coded decimal digits. It steps once for each single-cycle count tick that arrives while enable is high. A slow timebase elsewhere in the chip supplies those ticks, typically at 1 kHz. A direction input selects counting up or counting down. In wrap mode the count rolls over between 9999 and 0000 in either direction. In stop mode the count freezes at the terminal value of the current direction, and it stays frozen until enable is taken low and then high again.

Four adjust pulses, one per decade, let an operator set the value by hand. Each adjust pulse moves its own digit one step in the selected direction. A carry or borrow from that step ripples into the higher digits, and the digits below it are left alone. A terminal-count output flags 9999 when counting up and 0000 when counting down.

Top module: `bcd_updown_counter`

## Requirements
- R1: While `rst` is 1 at a rising clock edge, every digit becomes 0 and any stopped state is cleared. The reset is synchronous.
- R2: With `up_dn`=1 (count up), `en`=1 and no adjust pulse, each cycle with `tick`=1 adds one to the decimal value. In wrap mode (`stop_mode`=0), 9999 is followed by 0000.
- R3: With `up_dn`=0 (count down), each live tick subtracts one. In wrap mode, 0000 is followed by 9999.
- R4: A tick that arrives while `en`=0 leaves the count unchanged.
- R5: Each digit `count_o[4k+3:4k]` (digit 0 is the least significant) always holds a value from 0 to 9. A digit passes a carry only when it goes from 9 to 0, and a borrow only when it goes from 0 to 9.
- R6: `rco_o` is 1 when `up_dn`=1 and the count is 9999, or when `up_dn`=0 and the count is 0000. Otherwise it is 0.
- R7: With `stop_mode`=1, a live tick that arrives at the terminal value does not change the count, and the block enters a stopped state. While stopped, ticks have no effect as long as `en` stays 1.
- R8: A stopped counter resumes only after `en` has been seen at 0 and then at 1. The first live tick after that advances the count, including the step past the terminal value. After that step, stop mode applies again.
- R9: A pulse on `adj[k]` steps digit k by one in the `up_dn` direction. The carry or borrow passes into the digits above k, and any carry or borrow out of the top digit is lost. Digits below k do not change. Adjust pulses work whatever the state of enable or the stopped state.
- R10: When a tick and an adjust pulse fall in the same cycle, the adjust step is applied and the tick is discarded.
- R11: When several `adj` bits are 1 in the same cycle, only the lowest-numbered one acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Single-cycle count request |
| en | input | 1 | Count enable; a low-then-high sequence re-arms a stopped counter |
| up_dn | input | 1 | Direction: 1 counts up, 0 counts down |
| stop_mode | input | 1 | 1 holds the count at the terminal value, 0 wraps |
| adj | input | DIGITS (4) | Per-digit step pulses, bit k for digit k |
| count_o | output | 4*DIGITS (16) | BCD count, digit k at bits 4k+3:4k |
| rco_o | output | 1 | Terminal count for the present direction |

## Verification
The bench builds the block with its defaults: four digits, and the lowest-numbered adjust pulse given priority. With four digits, one full revolution takes 10,000 ticks, so both wrap points and both terminal values are reached in a short run. Borrows that ripple through every digit, and a carry lost off the top digit, both come up naturally. Keeping the default priority means that simultaneous adjust pulses are always resolved toward the low digit. A behavioural model that works on a plain decimal integer, taken modulo 10,000, tracks the count, the stopped and re-armed states, and the terminal flag on every cycle. Random phases then mix ticks, adjust pulses, resets and changes of enable, direction and mode.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;

   localparam int unsigned DIGIT_W = 4;

   typedef logic [DIGIT_W-1:0] bcd_digit_t;

   typedef enum logic [1:0] {
      RUN_S   = 2'd0,
      HALT_S  = 2'd1,
      REARM_S = 2'd2
   } run_state_e;

endpackage

// File: rtl/bcd_decade.sv
module bcd_decade
   import bcd_cnt_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       step_i,
   input  logic       up_i,
   output bcd_digit_t digit_o,
   output logic       carry_o,
   output logic       is_nine_o,
   output logic       is_zero_o
);

   bcd_digit_t d_q, d_next;
   logic       at_edge;

   always_comb begin
      is_nine_o = (d_q == bcd_digit_t'(9));
      is_zero_o = (d_q == bcd_digit_t'(0));
      at_edge   = up_i ? is_nine_o : is_zero_o;
      carry_o   = step_i & at_edge;
      if (up_i) d_next = at_edge ? bcd_digit_t'(0) : d_q + bcd_digit_t'(1);
      else      d_next = at_edge ? bcd_digit_t'(9) : d_q - bcd_digit_t'(1);
   end

   always_ff @(posedge clk) begin
      if (rst)         d_q <= '0;
      else if (step_i) d_q <= d_next;
   end

   assign digit_o = d_q;

   AST_DIGIT_LEGAL: assert property (@(posedge clk) disable iff (rst)
      d_q <= bcd_digit_t'(9)); // R5
   AST_DIGIT_QUIET: assert property (@(posedge clk) disable iff (rst)
      !step_i |=> $stable(d_q)); // R9
   AST_NINE_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
      (step_i && up_i && d_q == bcd_digit_t'(9)) |=> d_q == bcd_digit_t'(0)); // R5

endmodule

// File: rtl/bcd_halt_ctrl.sv
module bcd_halt_ctrl
   import bcd_cnt_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic tick_i,
   input  logic en_i,
   input  logic stop_i,
   input  logic term_i,
   input  logic adj_any_i,
   output logic advance_o,
   output logic halted_o
);

   run_state_e st_q, st_d;
   logic       live_tick;

   assign live_tick = tick_i & en_i & ~adj_any_i;

   always_comb begin
      st_d      = st_q;
      advance_o = 1'b0;
      unique case (st_q)
         RUN_S: begin
            if (live_tick) begin
               if (stop_i && term_i) st_d      = HALT_S;
               else                  advance_o = 1'b1;
            end
         end
         HALT_S: begin
            if (!en_i) st_d = REARM_S;
         end
         REARM_S: begin
            if (live_tick) begin
               advance_o = 1'b1;
               st_d      = RUN_S;
            end
         end
         default: st_d = RUN_S;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st_q <= RUN_S;
      else     st_q <= st_d;
   end

   assign halted_o = (st_q == HALT_S);

   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
      (st_q == HALT_S && en_i) |=> (st_q == HALT_S)); // R8
   AST_STOP_AT_TERM: assert property (@(posedge clk) disable iff (rst)
      (st_q == RUN_S && live_tick && stop_i && term_i) |=> (st_q == HALT_S)); // R7

endmodule

// File: rtl/bcd_updown_counter.sv
module bcd_updown_counter
   import bcd_cnt_pkg::*;
#(
   parameter int unsigned DIGITS        = 4,
   parameter bit          ADJ_LOW_FIRST = 1'b1,
   localparam int unsigned CNT_W        = DIGITS * DIGIT_W
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              en,
   input  logic              up_dn,
   input  logic              stop_mode,
   input  logic [DIGITS-1:0] adj,
   output logic [CNT_W-1:0]  count_o,
   output logic              rco_o
);

   if (DIGITS < 1 || DIGITS > 8) begin : g_bad_digits
      $error("bcd_updown_counter: DIGITS must be between 1 and 8");
   end

   logic [DIGITS-1:0] sel, inject, cin, cout, nine, zero;
   logic              adj_any, advance, halted, terminal;

   assign adj_any = |adj;

   if (ADJ_LOW_FIRST) begin : g_pick_low
      assign sel = adj & (~adj + DIGITS'(1));
   end else begin : g_pick_high
      always_comb begin
         sel = '0;
         for (int k = 0; k < DIGITS; k++) begin
            if (adj[k]) begin
               sel    = '0;
               sel[k] = 1'b1;
            end
         end
      end
   end

   assign terminal = up_dn ? (&nine) : (&zero);
   assign rco_o    = terminal;

   bcd_halt_ctrl u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .tick_i    (tick),
      .en_i      (en),
      .stop_i    (stop_mode),
      .term_i    (terminal),
      .adj_any_i (adj_any),
      .advance_o (advance),
      .halted_o  (halted)
   );

   for (genvar k = 0; k < DIGITS; k++) begin : g_dec
      if (k == 0) begin : g_first
         assign inject[k] = sel[k] | advance;
         assign cin[k]    = inject[k];
      end else begin : g_rest
         assign inject[k] = sel[k];
         assign cin[k]    = inject[k] | cout[k-1];
      end

      bcd_decade u_dec (
         .clk       (clk),
         .rst       (rst),
         .step_i    (cin[k]),
         .up_i      (up_dn),
         .digit_o   (count_o[k*DIGIT_W +: DIGIT_W]),
         .carry_o   (cout[k]),
         .is_nine_o (nine[k]),
         .is_zero_o (zero[k])
      );
   end

   AST_RESET_ZERO: assert property (@(posedge clk)
      rst |=> (count_o == '0)); // R1
   AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
      (halted && !adj_any) |=> $stable(count_o)); // R7

   if (DIGITS > 1) begin : g_tick_drop_chk
      AST_TICK_DROPPED: assert property (@(posedge clk) disable iff (rst)
         (tick && en && adj_any && !adj[0]) |=> $stable(count_o[DIGIT_W-1:0])); // R10
   end

endmodule

// File: tb/bcd_updown_counter_tb_top.sv
module bcd_updown_counter_tb_top;

   localparam int ND  = 4;
   localparam int MOD = 10000;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          tick = 1'b0, en = 1'b0, up_dn = 1'b1, stop_mode = 1'b0;
   logic [ND-1:0] adj = '0;
   logic [15:0]   count_o;
   logic          rco_o;

   int    nchk = 0, nerr = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   int mv = 0;
   int ms = 0;
   bit mvalid = 1'b0;

   always #2 clk = ~clk;

   bcd_updown_counter #(.DIGITS(ND), .ADJ_LOW_FIRST(1'b1)) dut_i (
      .clk(clk), .rst(rst), .tick(tick), .en(en), .up_dn(up_dn),
      .stop_mode(stop_mode), .adj(adj), .count_o(count_o), .rco_o(rco_o)
   );

   function automatic logic [15:0] to_bcd(int v);
      logic [15:0] r = '0;
      int t = v;
      for (int k = 0; k < 4; k++) begin
         r[k*4 +: 4] = 4'(t % 10);
         t = t / 10;
      end
      return r;
   endfunction

   function automatic int stepv(int v, int amt, logic up);
      return up ? (v + amt) % MOD : (v - amt + MOD) % MOD;
   endfunction

   // behavioural reference, updated on every rising edge
   always @(posedge clk) begin
      if (rst) begin
         mv = 0; ms = 0; mvalid = 1'b1;
      end else if (mvalid) begin
         bit term, live;
         int amt;
         term = up_dn ? (mv == MOD - 1) : (mv == 0);
         live = tick && en && (adj == '0);
         if (adj != '0) begin
            amt = 1;
            for (int k = 0; k < ND; k++) begin
               if (adj[k]) break;
               amt = amt * 10;
            end
            mv = stepv(mv, amt, up_dn);
         end
         case (ms)
            0: if (live) begin
                  if (stop_mode && term) ms = 1;
                  else mv = stepv(mv, 1, up_dn);
               end
            1: if (!en) ms = 2;
            default: if (live) begin
                  mv = stepv(mv, 1, up_dn);
                  ms = 0;
               end
         endcase
      end
   end

   // per-cycle comparison, 1 ns after the edge
   always @(posedge clk) begin
      #1;
      if (mvalid && !done) begin
         logic [15:0] ec;
         logic        er;
         ec = to_bcd(mv);
         er = up_dn ? (mv == MOD - 1) : (mv == 0);
         nchk++;
         if (count_o !== ec || rco_o !== er) begin
            nerr++;
            $display("FAIL %s model: count=%h rco=%b expected count=%h rco=%b",
                     cur_req, count_o, rco_o, ec, er);
         end
      end
   end

   task automatic chk(string req, logic [15:0] ec, logic er);
      nchk++;
      if (count_o !== ec || rco_o !== er) begin
         nerr++;
         $display("FAIL %s count=%h rco=%b expected count=%h rco=%b",
                  req, count_o, rco_o, ec, er);
      end
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic pulse(logic t, logic [ND-1:0] a);
      @(negedge clk); tick = t; adj = a;
      @(negedge clk); tick = 1'b0; adj = '0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nchk++; nerr++;
         $display("FAIL watchdog: run did not complete, expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      rst = 1'b0;
      cur_req = "R1";
      chk("R1", 16'h0000, 1'b0);

      cur_req = "R2"; en = 1'b1; up_dn = 1'b1;
      ticks(9999);
      chk("R2", 16'h9999, 1'b1);   // R6 terminal flag in up mode
      ticks(1);
      chk("R2", 16'h0000, 1'b0);
      ticks(6);
      chk("R2", 16'h0006, 1'b0);

      cur_req = "R4"; en = 1'b0;
      ticks(20);
      chk("R4", 16'h0006, 1'b0);

      cur_req = "R3"; en = 1'b1; up_dn = 1'b0;
      ticks(10);
      chk("R3", 16'h9996, 1'b0);

      cur_req = "R1";
      do_reset();
      chk("R1", 16'h0000, 1'b1);   // down mode at zero raises rco (R6)

      cur_req = "R9"; en = 1'b0; up_dn = 1'b1;
      pulse(1'b0, 4'b0010);
      chk("R9", 16'h0010, 1'b0);
      for (int i = 0; i < 9; i++) pulse(1'b0, 4'b0001);
      chk("R9", 16'h0019, 1'b0);
      pulse(1'b0, 4'b0001);
      chk("R5", 16'h0020, 1'b0);
      up_dn = 1'b0;
      pulse(1'b0, 4'b0100);
      chk("R9", 16'h9920, 1'b0);
      pulse(1'b0, 4'b1000);
      chk("R9", 16'h8920, 1'b0);
      up_dn = 1'b1;
      pulse(1'b0, 4'b1000);
      pulse(1'b0, 4'b1000);
      chk("R9", 16'h0920, 1'b0);

      cur_req = "R10"; en = 1'b1;
      pulse(1'b1, 4'b0100);
      chk("R10", 16'h1020, 1'b0);

      cur_req = "R11";
      pulse(1'b0, 4'b1010);
      chk("R11", 16'h1030, 1'b0);

      cur_req = "R7";
      do_reset();
      up_dn = 1'b0; stop_mode = 1'b0;
      ticks(2);
      chk("R3", 16'h9998, 1'b0);
      up_dn = 1'b1; stop_mode = 1'b1;
      ticks(1);
      chk("R6", 16'h9999, 1'b1);
      ticks(4);
      chk("R7", 16'h9999, 1'b1);

      cur_req = "R8";
      @(negedge clk); en = 1'b0;
      @(negedge clk); en = 1'b1;
      ticks(1);
      chk("R8", 16'h0000, 1'b0);
      ticks(1);
      chk("R8", 16'h0001, 1'b0);

      cur_req = "R7";
      do_reset();
      up_dn = 1'b0;
      ticks(3);
      chk("R7", 16'h0000, 1'b1);
      pulse(1'b0, 4'b0001);
      chk("R9", 16'h9999, 1'b0);
      ticks(2);
      chk("R8", 16'h9999, 1'b0);
      cur_req = "R8";
      @(negedge clk); en = 1'b0;
      @(negedge clk); en = 1'b1;
      ticks(1);
      chk("R8", 16'h9998, 1'b0);

      cur_req = "mixed R2 R3 R7 R8 R9";
      for (int i = 0; i < 6000; i++) begin
         @(negedge clk);
         tick = 1'($urandom % 2);
         adj  = ($urandom % 12 == 0) ? 4'($urandom % 16) : 4'b0000;
         if ($urandom % 24 == 0)   en = ~en;
         if ($urandom % 300 == 0)  up_dn = ~up_dn;
         if ($urandom % 200 == 0)  stop_mode = ~stop_mode;
         rst = ($urandom % 1500 == 0);
      end
      @(negedge clk); tick = 1'b0; adj = '0; rst = 1'b0;
      @(negedge clk);
      finish_run();
   end

endmodule